// File: doc/BRIEF.md
# I2C GPIO Expander Register File

This block holds the registers of an 8-bit I2C port expander and the pointer that picks one of them. A byte-level I2C target front end feeds it decoded events. These are: our address was matched, along with the read/write direction bit; a data byte was received; a read byte is wanted; and a stop was seen. The block returns the byte to be shifted out. It also drives the value and the per-pin driver enable for the expander's pins.

A small transaction state machine tracks where the bus is.

States:
- `ST_IDLE`: no transaction.
- `ST_CMD`: addressed for a write, waiting for the command byte.
- `ST_DATA`: command taken; following bytes are register data.
- `ST_READ`: addressed for a read.

Transitions:
- `IDLE_TO_CMD`: address match with the write direction, from any state. This also covers a repeated start.
- `ANY_TO_READ`: address match with the read direction, from any state.
- `CMD_TO_DATA`: first received byte.
- `DATA_HOLD`: further bytes stay in `ST_DATA`.
- `ANY_TO_IDLE`: stop, which takes priority over every other event.

The pointer is loaded only on `CMD_TO_DATA` and is never advanced. Consecutive reads therefore return the same register until a new command byte arrives.

Top module: `gpio_expander_regs`

## Requirements
- R1: After reset the output register is all ones, the polarity register is all zeros, the configuration register is all ones and the pointer selects the input register. So `port_out` is all ones, `port_oe` is all zeros, and a read returns the pins unchanged.
- R2: In a write transaction the first byte after the address match is the command byte. Only its bits [1:0] are kept: 0 input, 1 output, 2 polarity, 3 configuration. Bits [7:2] are ignored.
- R3: Every further byte of the same write goes to the selected register, and all of them go to that same register (no increment).
- R4: Bytes written while the input register is selected change no register.
- R5: A read transaction never changes the pointer. Each read request returns the selected register, repeatedly.
- R6: On a read request, `rd_data` is loaded one cycle later with the selected value. For the input register that value is `pin_in` XOR polarity, sampled in the request cycle. `rd_data` holds until the next request.
- R7: `port_out` equals the output register. Bit i of `port_oe` is the inverse of configuration bit i, where configuration bit 1 means input (driver off).
- R8: A stop returns the machine to idle. Bytes received while idle or during a read change nothing.
- R9: An address match with the write direction, even without a preceding stop, makes the next byte a command byte again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ev_addr | input | 1 | Pulse: own address matched |
| ev_addr_rd | input | 1 | Direction bit with `ev_addr` (1 = read) |
| ev_byte | input | 1 | Pulse: data byte received |
| byte_in | input | WIDTH | Received byte |
| ev_rd_req | input | 1 | Pulse: read byte requested |
| ev_stop | input | 1 | Pulse: stop condition |
| pin_in | input | WIDTH | Sampled pin levels |
| rd_data | output | WIDTH | Byte to transmit |
| port_out | output | WIDTH | Pin output values |
| port_oe | output | WIDTH | Per-pin driver enable (1 = drive) |

## Verification
The bench builds the block with its default WIDTH of 8. That makes the 2-bit pointer reach all four register selections, and lets the whole byte range of commands, data and pin patterns be driven. Random transactions interleave writes, reads, stray bytes, repeated starts and stops against a bench model. Directed cases cover commands with high bits set, multi-byte writes, writes to the input register and inverted-pin reads.

// File: rtl/gpx_pkg.sv
package gpx_pkg;
    typedef enum logic [1:0] {
        SEL_INPUT    = 2'd0,
        SEL_OUTPUT   = 2'd1,
        SEL_POLARITY = 2'd2,
        SEL_CONFIG   = 2'd3
    } reg_sel_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_CMD,
        ST_DATA,
        ST_READ
    } txn_state_e;
endpackage

// File: rtl/gpx_txn_fsm.sv
module gpx_txn_fsm
    import gpx_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ev_addr,
    input  logic             ev_addr_rd,
    input  logic             ev_byte,
    input  logic             ev_stop,
    input  logic [WIDTH-1:0] byte_in,
    output reg_sel_e         ptr_q,
    output logic             wr_en
);
    txn_state_e state_q, state_d;
    logic       cmd_load;

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: state_d = ST_IDLE;
            ST_CMD:  if (ev_byte) state_d = ST_DATA;
            ST_DATA: state_d = ST_DATA;
            ST_READ: state_d = ST_READ;
        endcase
        if (ev_stop)
            state_d = ST_IDLE;
        else if (ev_addr)
            state_d = ev_addr_rd ? ST_READ : ST_CMD;
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // outputs
    always_comb begin
        cmd_load = (state_q == ST_CMD)  && ev_byte && !ev_stop && !ev_addr;
        wr_en    = (state_q == ST_DATA) && ev_byte && !ev_stop && !ev_addr;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        ptr_q <= SEL_INPUT;
        else if (cmd_load) ptr_q <= reg_sel_e'(byte_in[1:0]);
    end

    assert_stop_idles_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ev_stop |=> (state_q == ST_IDLE));

    assert_read_keeps_ptr_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_READ) |=> $stable(ptr_q));
endmodule

// File: rtl/gpx_reg_bank.sv
module gpx_reg_bank
    import gpx_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  reg_sel_e         sel,
    input  logic [WIDTH-1:0] wdata,
    output logic [WIDTH-1:0] out_q,
    output logic [WIDTH-1:0] pol_q,
    output logic [WIDTH-1:0] cfg_q
);
    localparam logic [WIDTH-1:0] ALL_ONES = {WIDTH{1'b1}};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_q <= ALL_ONES;
            pol_q <= '0;
            cfg_q <= ALL_ONES;
        end else if (wr_en) begin
            unique case (sel)
                SEL_INPUT:    ;
                SEL_OUTPUT:   out_q <= wdata;
                SEL_POLARITY: pol_q <= wdata;
                SEL_CONFIG:   cfg_q <= wdata;
            endcase
        end
    end

    assert_input_write_ignored_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && sel == SEL_INPUT) |=> ($stable(out_q) && $stable(pol_q) && $stable(cfg_q)));
endmodule

// File: rtl/gpx_read_path.sv
module gpx_read_path
    import gpx_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rd_req,
    input  reg_sel_e         sel,
    input  logic [WIDTH-1:0] pins,
    input  logic [WIDTH-1:0] out_q,
    input  logic [WIDTH-1:0] pol_q,
    input  logic [WIDTH-1:0] cfg_q,
    output logic [WIDTH-1:0] rd_data
);
    logic [WIDTH-1:0] sel_val;

    always_comb begin
        unique case (sel)
            SEL_INPUT:    sel_val = pins ^ pol_q;
            SEL_OUTPUT:   sel_val = out_q;
            SEL_POLARITY: sel_val = pol_q;
            SEL_CONFIG:   sel_val = cfg_q;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      rd_data <= '0;
        else if (rd_req) rd_data <= sel_val;
    end

    assert_rd_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_req |=> $stable(rd_data));
endmodule

// File: rtl/gpio_expander_regs.sv
module gpio_expander_regs
    import gpx_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ev_addr,
    input  logic             ev_addr_rd,
    input  logic             ev_byte,
    input  logic [WIDTH-1:0] byte_in,
    input  logic             ev_rd_req,
    input  logic             ev_stop,
    input  logic [WIDTH-1:0] pin_in,
    output logic [WIDTH-1:0] rd_data,
    output logic [WIDTH-1:0] port_out,
    output logic [WIDTH-1:0] port_oe
);
    reg_sel_e         ptr;
    logic             wr_en;
    logic [WIDTH-1:0] out_q, pol_q, cfg_q;

    gpx_txn_fsm #(.WIDTH(WIDTH)) u_fsm (
        .clk(clk), .rst_n(rst_n), .ev_addr(ev_addr), .ev_addr_rd(ev_addr_rd),
        .ev_byte(ev_byte), .ev_stop(ev_stop), .byte_in(byte_in),
        .ptr_q(ptr), .wr_en(wr_en)
    );

    gpx_reg_bank #(.WIDTH(WIDTH)) u_bank (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .sel(ptr), .wdata(byte_in),
        .out_q(out_q), .pol_q(pol_q), .cfg_q(cfg_q)
    );

    gpx_read_path #(.WIDTH(WIDTH)) u_rd (
        .clk(clk), .rst_n(rst_n), .rd_req(ev_rd_req), .sel(ptr), .pins(pin_in),
        .out_q(out_q), .pol_q(pol_q), .cfg_q(cfg_q), .rd_data(rd_data)
    );

    assign port_out = out_q;

    // R7: per-pin driver enable is the inverse of the direction bit
    for (genvar i = 0; i < WIDTH; i++) begin : g_oe
        assign port_oe[i] = ~cfg_q[i];
    end
endmodule

// File: tb/gpio_expander_regs_tb.sv
module gpio_expander_regs_tb;
    localparam int W = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ev_addr = 0, ev_addr_rd = 0, ev_byte = 0, ev_rd_req = 0, ev_stop = 0;
    logic [W-1:0] byte_in = '0, pin_in = '0;
    logic [W-1:0] rd_data, port_out, port_oe;

    int checks = 0, fails = 0;
    bit done = 0;

    // bench model; states 0 idle, 1 cmd, 2 data, 3 read
    logic [W-1:0] m_out, m_pol, m_cfg;
    logic [1:0]   m_ptr;
    int           m_st;

    always #4 clk = ~clk;

    gpio_expander_regs #(.WIDTH(W)) u_dut (
        .clk(clk), .rst_n(rst_n), .ev_addr(ev_addr), .ev_addr_rd(ev_addr_rd),
        .ev_byte(ev_byte), .byte_in(byte_in), .ev_rd_req(ev_rd_req),
        .ev_stop(ev_stop), .pin_in(pin_in), .rd_data(rd_data),
        .port_out(port_out), .port_oe(port_oe)
    );

    function automatic logic [W-1:0] exp_read(input logic [1:0] p, input logic [W-1:0] pins);
        case (p)
            2'd0:    return pins ^ m_pol;
            2'd1:    return m_out;
            2'd2:    return m_pol;
            default: return m_cfg;
        endcase
    endfunction

    task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic addr(input bit rd);
        @(negedge clk); ev_addr = 1; ev_addr_rd = rd;
        @(negedge clk); ev_addr = 0;
        m_st = rd ? 3 : 1;
    endtask

    task automatic send(input logic [W-1:0] b);
        @(negedge clk); ev_byte = 1; byte_in = b;
        @(negedge clk); ev_byte = 0;
        if (m_st == 1) begin
            m_ptr = b[1:0]; m_st = 2;
        end else if (m_st == 2) begin
            case (m_ptr)
                2'd1: m_out = b;
                2'd2: m_pol = b;
                2'd3: m_cfg = b;
                default: ;
            endcase
        end
    endtask

    task automatic stop();
        @(negedge clk); ev_stop = 1;
        @(negedge clk); ev_stop = 0;
        m_st = 0;
    endtask

    task automatic rd(input logic [W-1:0] pins, input string req);
        logic [W-1:0] e;
        @(negedge clk); ev_rd_req = 1; pin_in = pins;
        e = exp_read(m_ptr, pins);
        @(negedge clk); ev_rd_req = 0; pin_in = ~pins;   // later pin change must not leak
        check(req, rd_data, e);
    endtask

    task automatic ports(input string req);
        check(req, port_out, m_out);
        check(req, port_oe, ~m_cfg);
    endtask

    initial begin
        #(200000 * 8);
        if (!done) begin
            fails++; checks++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5eed));
        m_out = '1; m_pol = '0; m_cfg = '1; m_ptr = 0; m_st = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1 reset state
        ports("R1 reset ports");
        addr(1); rd(8'h96, "R1 reset read input"); stop();

        // R2, R3: command with high bits, two data bytes into output
        addr(0); send(8'hFD); send(8'h5A); send(8'hC3); stop();
        ports("R3 multi-byte output");
        // R5: repeated reads of same register
        addr(1); rd(8'h00, "R5 read 1"); rd(8'hFF, "R5 read 2"); rd(8'h11, "R5 read 3"); stop();
        // R6: polarity then input read
        addr(0); send(8'h02); send(8'h0F); stop();
        addr(0); send(8'h00); stop();
        addr(1); rd(8'hA5, "R6 inverted input"); rd(8'h3C, "R6 inverted input 2"); stop();
        // R4: write aimed at input is ignored
        addr(0); send(8'h00); send(8'h12); send(8'h34); stop();
        ports("R4 input write ignored");
        addr(0); send(8'h02); stop();
        addr(1); rd(8'h00, "R4 polarity unchanged"); stop();
        // R8: stray bytes when idle and during read
        send(8'h00); send(8'h01);
        addr(1); send(8'h03); send(8'h77); rd(8'h00, "R8 byte in read ignored"); stop();
        ports("R8 stray bytes ignored");
        // R9: repeated start
        addr(0); send(8'h03); send(8'h0F); addr(0); send(8'h01); send(8'h33); stop();
        ports("R9 repeated start");
        addr(1); rd(8'h00, "R9 pointer after repeated start"); stop();
        // R2: config select via high-bit command
        addr(0); send(8'hAB); send(8'hF0); stop();
        ports("R2 R7 config select");

        // constrained random
        for (int i = 0; i < 600; i++) begin
            int op;
            op = $urandom_range(0, 5);
            case (op)
                0: addr(0);
                1: addr(1);
                2, 3: send(W'($urandom));
                4: stop();
                default: if (m_st == 3) rd(W'($urandom), "R5 R6 random read");
                         else ports("R3 R7 random ports");
            endcase
        end
        stop();
        ports("R7 final ports");

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule